// File: doc/BRIEF.md
# Fixed-Point Biquad Loop Filter

This block is the loop filter of a digital phase-locked loop. Each time a signed phase or period error sample arrives with a valid strobe, it runs a second-order recursive filter over that sample and its stored history. It then emits a signed frequency-control word for a tunable oscillator. The filter is a direct-form-I biquad. Its five coefficients are fixed-point integers with 38 fractional bits. All products and the running sum are 64-bit two's-complement values that wrap on overflow. The 64-bit sum is shifted right arithmetically by 38 and cut to the data width. A programmable base offset is then added to give the output word.

The history keeps the two previous inputs and the two previous filter results. The stored results do not include the base offset, so a change of base moves the output but leaves the loop dynamics alone. The products are formed by a parameterised engine. By default it uses one multiplier over five cycles. It can instead use five multipliers and finish in a single cycle. While a sample is in flight the block reports busy. During that time it refuses further samples, and it refuses writes to its coefficients and base. A synchronous clear empties the history and abandons any computation in progress.

Top module: `lf_biquad`

## Requirements
- R1: After reset, busy, drop and out_valid are low, out_word is zero, and the coefficients hold their parameter defaults: b0=10905723400, b1=21811446800, b2=10905723400, a1=-381134538612, a2=149879525269. The base offset is zero.
- R2: For an accepted sample x, the filter result is y = (b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2) with 64-bit wrapping arithmetic, shifted right arithmetically by 38, keeping the low 32 bits as a signed value.
- R3: out_word equals base + y, modulo 2^32.
- R4: After each output, x2 takes x1, x1 takes x, y2 takes y1 and y1 takes y. The stored y values exclude the base offset.
- R5: With the default single-multiplier engine, out_valid is a one-cycle pulse at the 5th rising edge after the edge that accepted the sample.
- R6: A sample is accepted when err_valid is high, busy is low and clear is low. busy is high from the accepting edge until the output edge, and low after that edge.
- R7: A sample presented while busy is high is discarded. drop pulses high for one cycle after that edge, and neither the pending output nor the history is affected.
- R8: Configuration writes (cfg_we high) select a register by cfg_addr: 0=b0, 1=b1, 2=b2, 3=a1, 4=a2 (all 64-bit cfg_wdata), and 5=base (cfg_wdata[31:0]). Addresses 6 and 7 are ignored. Writes made while busy is high are ignored.
- R9: clear zeroes all four history values. It aborts a computation in progress, so no output is produced, and busy is low after the clear edge. A sample presented in the same cycle as clear is discarded without a drop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Synchronous history clear and abort |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 64 | Configuration write data |
| err_valid | input | 1 | Error sample strobe |
| err_data | input | 32 | Signed error sample |
| busy | output | 1 | Computation in progress |
| drop | output | 1 | Pulse: a sample was discarded while busy |
| out_valid | output | 1 | Pulse: out_word updated |
| out_word | output | 32 | Signed frequency-control word |

## Verification
The assertions assume that clear is only asserted by its owner for single cycles or short bursts, and that a drop can only follow a sample the bench offered during a busy window. They do not constrain err_data. The stimulus keeps error samples within ±16384, the range a wrapped phase error takes. Random coefficient sets stay below 2^40 in magnitude. With these limits the bench model can track the design sample by sample. Overflow wrap is still modelled with the same 64-bit arithmetic as the requirement states. Intruding samples, mid-computation writes and clears are timed by the bench against the known five-cycle window.

// File: rtl/lf_biquad_pkg.sv
package lf_biquad_pkg;
   localparam int NTERMS   = 5;  // b0, b1, b2, a1, a2
   localparam int FB_FIRST = 3;  // terms at and above this index are subtracted
   localparam int ADDR_W   = 3;
   localparam logic [ADDR_W-1:0] SEL_BASE = 3'd5;
endpackage

// File: rtl/lf_coef_bank.sv
module lf_coef_bank
   import lf_biquad_pkg::*;
#(
   parameter int     DATA_W = 32,
   parameter int     COEF_W = 64,
   parameter longint B0     = 64'sd10905723400,
   parameter longint B1     = 64'sd21811446800,
   parameter longint B2     = 64'sd10905723400,
   parameter longint A1     = -64'sd381134538612,
   parameter longint A2     = 64'sd149879525269
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [COEF_W-1:0]        wr_data,
   output logic signed [COEF_W-1:0] coef_o [NTERMS],
   output logic [DATA_W-1:0]        base_o
);
   localparam longint RST_VAL [NTERMS] = '{B0, B1, B2, A1, A2};

   for (genvar i = 0; i < NTERMS; i++) begin : g_coef
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            coef_o[i] <= COEF_W'(RST_VAL[i]);
         else if (wr_en && wr_addr == ADDR_W'(i))
            coef_o[i] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base_o <= '0;
      else if (wr_en && wr_addr == SEL_BASE)
         base_o <= wr_data[DATA_W-1:0];
   end
endmodule

// File: rtl/lf_history.sv
module lf_history #(
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     shift,
   input  logic signed [DATA_W-1:0] x_new,
   input  logic signed [DATA_W-1:0] y_new,
   output logic signed [DATA_W-1:0] x1,
   output logic signed [DATA_W-1:0] x2,
   output logic signed [DATA_W-1:0] y1,
   output logic signed [DATA_W-1:0] y2
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x1 <= '0; x2 <= '0; y1 <= '0; y2 <= '0;
      end else if (clr) begin
         x1 <= '0; x2 <= '0; y1 <= '0; y2 <= '0;
      end else if (shift) begin
         x2 <= x1;
         x1 <= x_new;
         y2 <= y1;
         y1 <= y_new;
      end
   end
endmodule

// File: rtl/lf_mac_engine.sv
module lf_mac_engine
   import lf_biquad_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int COEF_W    = 64,
   parameter int MAC_LANES = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     abort,
   input  logic                     start,
   input  logic signed [COEF_W-1:0] coef [NTERMS],
   input  logic signed [DATA_W-1:0] opnd [NTERMS],
   output logic                     run_o,
   output logic                     fin_o,
   output logic signed [COEF_W-1:0] sum_o
);
   function automatic logic signed [COEF_W-1:0] term(
      input logic signed [COEF_W-1:0] c,
      input logic signed [DATA_W-1:0] v,
      input logic                     fb
   );
      logic signed [COEF_W-1:0] ve;
      logic signed [COEF_W-1:0] p;
      ve = COEF_W'(v);
      p  = c * ve;
      return fb ? -p : p;
   endfunction

   if (MAC_LANES == NTERMS) begin : g_par
      logic run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     run_q <= 1'b0;
         else if (abort) run_q <= 1'b0;
         else            run_q <= start;
      end
      always_comb begin
         logic signed [COEF_W-1:0] acc;
         acc = '0;
         for (int i = 0; i < NTERMS; i++)
            acc = acc + term(coef[i], opnd[i], i >= FB_FIRST);
         sum_o = acc;
      end
      assign run_o = run_q;
      assign fin_o = run_q;
   end else begin : g_ser
      localparam int IDX_W = $clog2(NTERMS);
      localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NTERMS - 1);
      localparam logic [IDX_W-1:0] IDX_FB   = IDX_W'(FB_FIRST);
      logic                     run_q;
      logic [IDX_W-1:0]         idx_q;
      logic signed [COEF_W-1:0] acc_q;

      assign fin_o = run_q && (idx_q == IDX_LAST);
      assign sum_o = acc_q + term(coef[idx_q], opnd[idx_q], idx_q >= IDX_FB);
      assign run_o = run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q <= 1'b0;
            idx_q <= '0;
            acc_q <= '0;
         end else if (abort) begin
            run_q <= 1'b0;
         end else if (start) begin
            run_q <= 1'b1;
            idx_q <= '0;
            acc_q <= '0;
         end else if (run_q) begin
            if (fin_o) begin
               run_q <= 1'b0;
            end else begin
               idx_q <= idx_q + 1'b1;
               acc_q <= sum_o;
            end
         end
      end
   end
endmodule

// File: rtl/lf_biquad.sv
module lf_biquad
   import lf_biquad_pkg::*;
#(
   parameter int     DATA_W    = 32,
   parameter int     COEF_W    = 64,
   parameter int     FRAC_W    = 38,
   parameter int     MAC_LANES = 1,
   parameter longint B0        = 64'sd10905723400,
   parameter longint B1        = 64'sd21811446800,
   parameter longint B2        = 64'sd10905723400,
   parameter longint A1        = -64'sd381134538612,
   parameter longint A2        = 64'sd149879525269
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [COEF_W-1:0] cfg_wdata,
   input  logic              err_valid,
   input  logic [DATA_W-1:0] err_data,
   output logic              busy,
   output logic              drop,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_word
);
   localparam int CFG_W = NTERMS * COEF_W + DATA_W;

   if (MAC_LANES != 1 && MAC_LANES != NTERMS) begin : g_bad_lanes
      $error("lf_biquad: MAC_LANES must be 1 or %0d", NTERMS);
   end
   if (FRAC_W <= 0 || FRAC_W >= COEF_W) begin : g_bad_frac
      $error("lf_biquad: FRAC_W must lie between 1 and COEF_W-1");
   end
   if (DATA_W > COEF_W) begin : g_bad_data
      $error("lf_biquad: DATA_W may not exceed COEF_W");
   end

   logic signed [COEF_W-1:0] coef [NTERMS];
   logic signed [DATA_W-1:0] opnd [NTERMS];
   logic [DATA_W-1:0]        base;
   logic signed [DATA_W-1:0] x0_q, x1, x2, y1, y2;
   logic signed [DATA_W-1:0] y_now;
   logic signed [COEF_W-1:0] sum;
   logic                     run, fin, accept, commit;
   logic [CFG_W-1:0]         cfg_image;

   assign busy   = run;
   assign accept = err_valid && !run && !clear;
   assign commit = fin && !clear;

   lf_coef_bank #(
      .DATA_W(DATA_W), .COEF_W(COEF_W),
      .B0(B0), .B1(B1), .B2(B2), .A1(A1), .A2(A2)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we && !run), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
      .coef_o(coef), .base_o(base)
   );

   lf_history #(.DATA_W(DATA_W)) u_hist (
      .clk(clk), .rst_n(rst_n), .clr(clear), .shift(commit),
      .x_new(x0_q), .y_new(y_now),
      .x1(x1), .x2(x2), .y1(y1), .y2(y2)
   );

   assign opnd[0] = x0_q;
   assign opnd[1] = x1;
   assign opnd[2] = x2;
   assign opnd[3] = y1;
   assign opnd[4] = y2;

   lf_mac_engine #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .MAC_LANES(MAC_LANES)
   ) u_mac (
      .clk(clk), .rst_n(rst_n), .abort(clear), .start(accept),
      .coef(coef), .opnd(opnd),
      .run_o(run), .fin_o(fin), .sum_o(sum)
   );

   assign y_now = DATA_W'(sum >>> FRAC_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x0_q      <= '0;
         out_valid <= 1'b0;
         out_word  <= '0;
         drop      <= 1'b0;
      end else begin
         if (accept) x0_q <= err_data;
         out_valid <= commit;
         drop      <= err_valid && run && !clear;
         if (commit) out_word <= base + y_now;
      end
   end

   always_comb begin
      for (int i = 0; i < NTERMS; i++)
         cfg_image[i*COEF_W +: COEF_W] = coef[i];
      cfg_image[NTERMS*COEF_W +: DATA_W] = base;
   end
endmodule

// File: rtl/lf_biquad_chk.sv
module lf_biquad_chk #(
   parameter int CFG_W = 352
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear,
   input logic             err_valid,
   input logic             busy,
   input logic             drop,
   input logic             out_valid,
   input logic [CFG_W-1:0] cfg_image
);
   AST_OUT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R5

   AST_OUT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (!busy && $past(busy))); // R6

   AST_BUSY_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(err_valid && !clear)); // R6

   AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      drop |-> $past(err_valid && busy && !clear)); // R7

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cfg_image)); // R8

   AST_CLEAR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!busy && !out_valid)); // R9
endmodule

bind lf_biquad lf_biquad_chk #(.CFG_W(CFG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clear(clear), .err_valid(err_valid),
   .busy(busy), .drop(drop), .out_valid(out_valid), .cfg_image(cfg_image)
);

// File: tb/tb_lf_biquad.sv
module tb_lf_biquad;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [63:0] cfg_wdata = '0;
   logic        err_valid = 1'b0;
   logic [31:0] err_data = '0;
   logic        busy, drop, out_valid;
   logic [31:0] out_word;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   longint m_c [5] = '{64'sd10905723400, 64'sd21811446800, 64'sd10905723400,
                       -64'sd381134538612, 64'sd149879525269};
   int m_base = 0;
   int m_x1 = 0, m_x2 = 0, m_y1 = 0, m_y2 = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lf_biquad dut (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .err_valid(err_valid), .err_data(err_data),
      .busy(busy), .drop(drop), .out_valid(out_valid), .out_word(out_word)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int model_step(input int x);
      longint s;
      int     y;
      s = m_c[0] * longint'(x) + m_c[1] * longint'(m_x1) + m_c[2] * longint'(m_x2)
        - m_c[3] * longint'(m_y1) - m_c[4] * longint'(m_y2);
      y = int'(s >>> 38);
      m_x2 = m_x1; m_x1 = x;
      m_y2 = m_y1; m_y1 = y;
      return m_base + y;
   endfunction

   task automatic cfg_write(input logic [2:0] a, input logic [63:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a < 3'd5) m_c[a] = longint'(d);
      else if (a == 3'd5) m_base = int'(d[31:0]);
   endtask

   task automatic do_clear();
      @(negedge clk);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      m_x1 = 0; m_x2 = 0; m_y1 = 0; m_y2 = 0;
   endtask

   // One sample through the filter, optionally with an intruding sample
   // and a configuration write while busy.
   task automatic send(input int x, input bit intrude, input int ix, input bit midcfg, input string req);
      int exp;
      exp = model_step(x);
      @(negedge clk);
      err_valid = 1'b1; err_data = x;
      @(negedge clk);
      err_valid = 1'b0;
      chk(busy === 1'b1, "R6 busy after accept", busy, 1);
      for (int k = 1; k < LAT; k++) begin
         if (k == 1 && intrude) begin err_valid = 1'b1; err_data = ix; end
         if (k == 2 && midcfg) begin
            cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 64'h0000_0100_0000_0000;
         end
         if (k == 3 && midcfg) begin
            cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 64'd77777;
         end
         @(negedge clk);
         err_valid = 1'b0; cfg_we = 1'b0;
         if (k == 1 && intrude) chk(drop === 1'b1, "R7 drop pulse", drop, 1);
         chk(out_valid === 1'b0 && busy === 1'b1, "R5 no early output", out_valid, 0);
      end
      @(negedge clk);
      chk(out_valid === 1'b1, "R5 output on 5th edge", out_valid, 1);
      chk(busy === 1'b0, "R6 busy low after output", busy, 0);
      chk(int'(out_word) == exp, req, int'(out_word), exp);
      @(negedge clk);
      chk(out_valid === 1'b0 && drop === 1'b0, "R5 single pulse", out_valid, 0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && out_valid === 1'b0 && drop === 1'b0, "R1 idle in reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_word === 32'd0, "R1 out_word zero", int'(out_word), 0);

      // R1/R2: default coefficients on an impulse and a step
      send(10000, 0, 0, 0, "R1 default coefficient impulse");
      for (int i = 0; i < 4; i++) send(0, 0, 0, 0, "R4 impulse tail from history");
      for (int i = 0; i < 4; i++) send(-16384, 0, 0, 0, "R2 negative step");

      // R3: base offset added after filtering, history stays offset-free
      cfg_write(3'd5, 64'hFFFF_FFFF_8000_0005);
      send(16384, 0, 0, 0, "R3 base plus filter");
      send(0, 0, 0, 0, "R4 offset-free history");
      cfg_write(3'd6, 64'd123);
      cfg_write(3'd7, 64'd456);
      send(500, 0, 0, 0, "R8 unmapped address ignored");

      // R7: intruding sample dropped
      send(1234, 1, 9999, 0, "R7 intruder no effect on output");
      send(-77, 0, 0, 0, "R7 intruder no effect on history");

      // R8: writes while busy ignored
      send(2000, 0, 0, 1, "R8 busy write ignored");
      send(2000, 0, 0, 0, "R8 coefficients unchanged");

      // R9: clear zeroes history
      do_clear();
      send(3000, 0, 0, 0, "R9 history zero after clear");

      // R9: clear mid-computation aborts without output
      @(negedge clk);
      err_valid = 1'b1; err_data = 32'd4321;
      @(negedge clk);
      err_valid = 1'b0;
      @(negedge clk);
      clear = 1'b1;
      err_valid = 1'b1; err_data = 32'd5;
      @(negedge clk);
      clear = 1'b0; err_valid = 1'b0;
      m_x1 = 0; m_x2 = 0; m_y1 = 0; m_y2 = 0;
      chk(busy === 1'b0, "R9 busy low after clear", busy, 0);
      chk(drop === 1'b0, "R9 no drop with clear", drop, 0);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk(out_valid === 1'b0 && busy === 1'b0, "R9 aborted, no output", out_valid, 0);
      end
      send(-1500, 0, 0, 0, "R9 fresh history after abort");

      // Random samples with default coefficients and random base
      for (int i = 0; i < 120; i++) begin
         if ($urandom_range(15) == 0)
            cfg_write(3'd5, 64'($urandom));
         send(int'($urandom_range(32768)) - 16384, ($urandom_range(7) == 0),
              int'($urandom), 0, "R2 random sample");
      end

      // Random coefficient sets
      for (int s = 0; s < 3; s++) begin
         for (int a = 0; a < 5; a++) begin
            longint v;
            v = longint'({$urandom, $urandom}) >>> 24;
            cfg_write(3'(a), 64'(v));
         end
         do_clear();
         for (int i = 0; i < 30; i++)
            send(int'($urandom_range(32768)) - 16384, 0, 0, 0, "R2 random coefficients");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule